// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave-side serial control port that gives a host read and write access to a small 8-bit register space over four wires: an active-low chip select, a serial clock, serial data in, and serial data out with its own output enable. Each frame carries a direction bit, a 7-bit address and one data byte. The block turns each frame into a single access on an internal register bus. A write frame ends in a one-cycle write strobe that carries the address and data. A read frame fetches the addressed byte and shifts it back out over the final eight serial clock periods.

The port runs entirely in the system clock domain. It passes chip select, serial clock and serial data through a synchronizer chain and finds the serial clock edges by comparing consecutive synchronized samples. The serial clock must therefore be several system clocks slower than the system clock. Only the low `LOC_AW` address bits reach the register bus. An address with any higher bit set is reserved. The register side is a plain combinational read port plus a write strobe, so a small register file or an inferred RAM can sit directly behind it.

Top module: `sport_serial_port`

## Requirements
- R1: A frame is 16 serial-clock bits, sampled on rising SCLK edges. Bit 0 is the direction bit. Bits 1..7 carry address bits A0..A6, least significant first. Bits 8..15 carry data bits D0..D7, least significant first.
- R2: A direction bit of 1 makes the frame a read. A direction bit of 0 makes it a write.
- R3: A complete write frame to a valid address produces exactly one `reg_we` pulse, one system clock wide. The pulse carries the frame's address on `reg_addr` and its data on `reg_wdata`. It is high in the third system clock cycle after the 16th rising SCLK edge appears at the pin, and low in the second.
- R4: A frame in which chip select is deasserted before the 16th rising SCLK edge produces no write strobe.
- R5: An address with any of A6..A4 nonzero is reserved. A write frame to a reserved address produces no strobe and changes no register.
- R6: A read frame to a reserved address returns the byte 0x00 on SDO.
- R7: `spi_sdo_oe` is low except in the data phase of a read. It rises on the falling SCLK edge that follows the 8th rising edge. After each falling edge that follows rising edges 8 through 15, SDO carries D0..D7 in order. `spi_sdo_oe` falls on the falling edge that follows the 16th rising edge.
- R8: Deasserting chip select forces `spi_sdo_oe` low and restarts bit counting, so that the next frame is decoded from its first bit.
- R9: The read byte is taken from the register bus once the seventh address bit has arrived. A later change to that register during the same frame does not alter the byte being shifted out.
- R10: After reset, `spi_sdo_oe`, `spi_sdo` and `reg_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low; frames a transaction |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out, meaningful while `spi_sdo_oe` is high |
| spi_sdo_oe | output | 1 | Output enable for the SDO pad driver |
| reg_addr | output | LOC_AW | Register bus address (low address bits of the frame) |
| reg_wdata | output | DATA_W | Register bus write data |
| reg_we | output | 1 | Register bus write strobe, one clock wide |
| reg_rdata | input | DATA_W | Register bus read data for `reg_addr` |

## Verification
Every pin event passes two synchronizer flops and one edge register before it reaches a registered output. The write strobe therefore rises in the third system clock after the pin edge, and each SDO bit and enable change appears three clocks after the falling SCLK edge. The bench drives pins on falling system clock edges. For every write it samples `reg_we` at the second and third falling system clock after the last rising SCLK, so it pins down both the cycle in which the strobe appears and the fact that there is no strobe on reserved or aborted frames. It samples SDO and its enable seven clocks after each falling SCLK. That is well past the three-cycle latency and before the next rising edge, so each bit is read in a stable window.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int unsigned SP_ADDR_W      = 7;
  localparam int unsigned SP_DATA_W      = 8;
  localparam int unsigned SP_LOC_AW      = 4;
  localparam int unsigned SP_SYNC_STAGES = 2;

  // synchronized pin events, one system clock wide
  typedef struct packed {
    logic cs_act;
    logic rise;
    logic fall;
    logic sdi;
  } sp_evt_t;
endpackage

// File: rtl/sport_pin_sync.sv
module sport_pin_sync
  import sport_pkg::*;
#(
  parameter int unsigned STAGES = SP_SYNC_STAGES
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cs_n,
  input  logic    sclk,
  input  logic    sdi,
  output sp_evt_t evt
);
  // bit 0: chip select (active low), bit 1: serial clock, bit 2: data
  localparam logic [2:0] PIN_IDLE = 3'b001;

  logic [STAGES-1:0][2:0] chain;
  logic                   sclk_d;
  logic [2:0]             pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= PIN_IDLE;
      sclk_d <= 1'b0;
    end else begin
      chain[0] <= {sdi, sclk, cs_n};
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      sclk_d <= pins_s[1];
    end
  end

  assign pins_s     = chain[STAGES-1];
  assign evt.cs_act = ~pins_s[0];
  assign evt.rise   = ~pins_s[0] &  pins_s[1] & ~sclk_d;
  assign evt.fall   = ~pins_s[0] & ~pins_s[1] &  sclk_d;
  assign evt.sdi    = pins_s[2];
endmodule

// File: rtl/sport_frame_rx.sv
module sport_frame_rx #(
  parameter int unsigned AW     = 7,
  parameter int unsigned DW     = 8,
  parameter int unsigned LAW    = 4,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act,
  input  logic             rise,
  input  logic             sdi,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             rw,
  output logic [AW-1:0]    addr,
  output logic             addr_ok,
  output logic [DW-1:0]    wdata,
  output logic             rd_load,
  output logic             we
);
  localparam int unsigned FRAME_BITS = 1 + AW + DW;
  localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(AW);
  localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] C_FULL     = CNT_W'(FRAME_BITS);

  // reserved-address decode: variant picked by how much of the address is local
  generate
    if (LAW >= AW) begin : g_all_local
      assign addr_ok = 1'b1;
    end else begin : g_upper_check
      assign addr_ok = (addr[AW-1:LAW] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      rw      <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
      rd_load <= 1'b0;
      we      <= 1'b0;
    end else begin
      rd_load <= 1'b0;
      we      <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
      end else if (rise && bit_cnt != C_FULL) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == '0)
          rw <= sdi;
        else if (bit_cnt <= C_ADDR_END)
          addr <= {sdi, addr[AW-1:1]};
        else
          wdata <= {sdi, wdata[DW-1:1]};
        if (bit_cnt == C_ADDR_END)
          rd_load <= 1'b1;
        if (bit_cnt == C_LAST && !rw && addr_ok)
          we <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sport_sdo_tx.sv
module sport_sdo_tx #(
  parameter int unsigned DW     = 8,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned DSTART = 8,
  parameter int unsigned FULL   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act,
  input  logic             fall,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             rw,
  input  logic             rd_load,
  input  logic [DW-1:0]    rd_byte,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam logic [CNT_W-1:0] C_DSTART = CNT_W'(DSTART);
  localparam logic [CNT_W-1:0] C_FULL   = CNT_W'(FULL);

  logic [DW-1:0] shreg;
  logic [DW-1:0] src;
  logic          data_phase;

  // a falling edge may land in the very cycle the read byte is loaded
  assign src        = rd_load ? rd_byte : shreg;
  assign data_phase = rw && bit_cnt >= C_DSTART && bit_cnt < C_FULL;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (!cs_act) begin
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (fall) begin
      if (data_phase) begin
        sdo    <= src[0];
        sdo_oe <= 1'b1;
        shreg  <= src >> 1;
      end else begin
        sdo    <= 1'b0;
        sdo_oe <= 1'b0;
        shreg  <= src;
      end
    end else begin
      shreg <= src;
    end
  end
endmodule

// File: rtl/sport_serial_port.sv
module sport_serial_port
  import sport_pkg::*;
#(
  parameter int unsigned ADDR_W      = SP_ADDR_W,
  parameter int unsigned DATA_W      = SP_DATA_W,
  parameter int unsigned LOC_AW      = SP_LOC_AW,
  parameter int unsigned SYNC_STAGES = SP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic [LOC_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  sp_evt_t           evt;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_ok;
  logic              rd_load;
  logic [DATA_W-1:0] rd_byte;

  sport_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .cs_n(spi_cs_n),
    .sclk(spi_sclk),
    .sdi (spi_sdi),
    .evt (evt)
  );

  sport_frame_rx #(
    .AW(ADDR_W), .DW(DATA_W), .LAW(LOC_AW), .CNT_W(CNT_W)
  ) i_rx (
    .clk    (clk),
    .rst    (rst),
    .cs_act (evt.cs_act),
    .rise   (evt.rise),
    .sdi    (evt.sdi),
    .bit_cnt(bit_cnt),
    .rw     (rw_q),
    .addr   (addr_q),
    .addr_ok(addr_ok),
    .wdata  (reg_wdata),
    .rd_load(rd_load),
    .we     (reg_we)
  );

  assign rd_byte  = addr_ok ? reg_rdata : '0;
  assign reg_addr = addr_q[LOC_AW-1:0];

  sport_sdo_tx #(
    .DW(DATA_W), .CNT_W(CNT_W), .DSTART(ADDR_W + 1), .FULL(FRAME_BITS)
  ) i_tx (
    .clk    (clk),
    .rst    (rst),
    .cs_act (evt.cs_act),
    .fall   (evt.fall),
    .bit_cnt(bit_cnt),
    .rw     (rw_q),
    .rd_load(rd_load),
    .rd_byte(rd_byte),
    .sdo    (spi_sdo),
    .sdo_oe (spi_sdo_oe)
  );
endmodule

// File: rtl/sport_serial_port_chk.sv
module sport_serial_port_chk #(
  parameter int unsigned AW     = 7,
  parameter int unsigned LAW    = 4,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned DSTART = 8,
  parameter int unsigned FULL   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_act,
  input logic             rw,
  input logic [CNT_W-1:0] cnt,
  input logic [AW-1:0]    addr,
  input logic             sdo_oe,
  input logic             sdo,
  input logic             reg_we
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R10: outputs quiet right after a reset cycle
  always_ff @(posedge clk) begin
    if (rst_q) assert_reset_quiet_R10: assert (!sdo_oe && !sdo && !reg_we);
  end

  assert_oe_read_phase_R7: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (rw && cnt >= CNT_W'(DSTART)));

  assert_oe_starts_d0_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> cnt == CNT_W'(DSTART));

  assert_we_full_frame_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (cnt == CNT_W'(FULL) && !rw));

  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_we_valid_addr_R5: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> ((addr >> LAW) == '0));

  assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sdo_oe);
endmodule

bind sport_serial_port sport_serial_port_chk #(
  .AW(ADDR_W), .LAW(LOC_AW), .CNT_W(CNT_W), .DSTART(ADDR_W + 1), .FULL(FRAME_BITS)
) i_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_act(evt.cs_act),
  .rw    (rw_q),
  .cnt   (bit_cnt),
  .addr  (addr_q),
  .sdo_oe(spi_sdo_oe),
  .sdo   (spi_sdo),
  .reg_we(reg_we)
);

// File: tb/test_sport_serial_port.sv
module test_sport_serial_port;
  localparam int LAW = 4;
  localparam int NREG = 1 << LAW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, reg_we;
  logic [LAW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] mem [NREG];
  logic [7:0] exp_mem [NREG];
  int we_cnt;
  logic poke_en = 1'b0;
  logic [LAW-1:0] poke_a = '0;
  logic [7:0] poke_d = '0;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sport_serial_port i_sport_serial_port (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  // register file on the bus side
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= 8'h00;
      we_cnt <= 0;
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        we_cnt <= we_cnt + 1;
      end
      if (poke_en) mem[poke_a] <= poke_d;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // one frame; nbits < 16 aborts it; poke rewrites the register mid-frame
  task automatic frame(input bit rw, input logic [6:0] a, input logic [7:0] d,
                       input int nbits, input bit poke, input logic [7:0] pval,
                       output logic [7:0] q, output bit w2, output bit w3,
                       output bit oe_ok);
    logic [15:0] b;
    b = {d, a, rw};
    q = '0; w2 = 0; w3 = 0; oe_ok = 1;
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      sdi = b[k];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      if (k == 15) begin
        repeat (2) @(negedge clk);
        w2 = reg_we;
        @(negedge clk);
        w3 = reg_we;
        repeat (5) @(negedge clk);
      end else if (k == 8 && poke) begin
        @(negedge clk);
        poke_a = a[LAW-1:0]; poke_d = pval; poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
        repeat (6) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      sclk = 1'b0;
      sdi = ~sdi;  // disturb data away from rising edges
      repeat (7) @(negedge clk);
      if (k >= 7 && k <= 14) begin
        q[k-7] = sdo;
        if (sdo_oe != rw) oe_ok = 0;
      end else if (sdo_oe) begin
        oe_ok = 0;
      end
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    if (sdo_oe) oe_ok = 0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] pat1(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    bit w2, w3, ok;
    int base;
    for (int i = 0; i < NREG; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!sdo_oe && !sdo && !reg_we, "R10 reset outputs", {sdo_oe, sdo, reg_we}, 0);

    // R1 R2 R3 R5: write sweep over every 7-bit address
    for (int a = 0; a < 128; a++) begin
      frame(1'b0, 7'(a), pat1(a), 16, 0, 8'h00, q, w2, w3, ok);
      if (a < NREG) begin
        chk(!w2 && w3, "R3 write strobe cycle", {w2, w3}, 1);
        exp_mem[a] = pat1(a);
      end else begin
        chk(!w3, "R5 reserved write strobe", w3, 0);
      end
      chk(ok, "R7 sdo_oe low in write", 0, 1);
    end
    chk(we_cnt == NREG, "R5 strobe count", we_cnt, NREG);

    // R1 R2 R6 R7: read sweep over every address
    for (int a = 0; a < 128; a++) begin
      frame(1'b1, 7'(a), 8'h00, 16, 0, 8'h00, q, w2, w3, ok);
      if (a < NREG) chk(q == exp_mem[a], "R2 read data", q, exp_mem[a]);
      else          chk(q == 8'h00, "R6 reserved read zero", q, 0);
      chk(ok, "R7 sdo_oe window", 0, 1);
      chk(!w3, "R2 no strobe on read", w3, 0);
    end

    // R1 second pattern: write then read with different bit patterns
    for (int a = 0; a < NREG; a++) begin
      frame(1'b0, 7'(a), 8'(a * 17) ^ 8'hA5, 16, 0, 8'h00, q, w2, w3, ok);
      exp_mem[a] = 8'(a * 17) ^ 8'hA5;
      frame(1'b1, 7'(a), 8'hFF, 16, 0, 8'h00, q, w2, w3, ok);
      chk(q == exp_mem[a], "R1 lsb-first pattern", q, exp_mem[a]);
      chk(reg_addr == 4'(a), "R1 address bits", reg_addr, a);
    end

    // R4: aborted writes at 15 and 9 bits
    base = we_cnt;
    frame(1'b0, 7'd2, 8'h3C, 15, 0, 8'h00, q, w2, w3, ok);
    frame(1'b0, 7'd2, 8'hC3, 9, 0, 8'h00, q, w2, w3, ok);
    chk(we_cnt == base, "R4 aborted frame strobe", we_cnt, base);
    frame(1'b1, 7'd2, 8'h00, 16, 0, 8'h00, q, w2, w3, ok);
    chk(q == exp_mem[2], "R4 register unchanged", q, exp_mem[2]);

    // R8: read aborted in the data phase releases SDO, next frame decodes
    frame(1'b1, 7'd5, 8'h00, 12, 0, 8'h00, q, w2, w3, ok);
    chk(ok, "R8 sdo released on cs", 0, 1);
    frame(1'b0, 7'd5, 8'h96, 16, 0, 8'h00, q, w2, w3, ok);
    chk(!w2 && w3, "R8 frame after abort", {w2, w3}, 1);
    exp_mem[5] = 8'h96;
    frame(1'b1, 7'd5, 8'h00, 16, 0, 8'h00, q, w2, w3, ok);
    chk(q == 8'h96, "R8 read after abort", q, 8'h96);

    // R9: register changes after capture do not reach SDO
    frame(1'b1, 7'd9, 8'h00, 16, 1, 8'hE1, q, w2, w3, ok);
    chk(q == exp_mem[9], "R9 captured byte", q, exp_mem[9]);
    exp_mem[9] = 8'hE1;
    frame(1'b1, 7'd9, 8'h00, 16, 0, 8'h00, q, w2, w3, ok);
    chk(q == 8'hE1, "R9 new value next frame", q, 8'hE1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule